// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execution core of a small processor: seven general-purpose 8-bit registers, two operand selectors, one shared ALU and a destination decoder. A sequencer outside the block presents one 14-bit control word each clock. The control word names the two ALU operands, the operation and the register that receives the result. Either operand can come from the external data input in place of a register. Fetch, sequencing and the control store that holds the control words are not part of this block.

The ALU result and a four-bit status vector (carry, sign, zero, overflow) are captured into output registers on every rising edge. Both therefore describe the control word that was applied in the previous cycle. On the same edge the result is written into the chosen register, or into none when the destination code is zero. The result reaches the output in either case.

Control word layout: bits [13:11] select operand A, bits [10:8] select operand B, bits [7:5] select the destination, and bits [4:0] give the operation.

Top module: `ctrl_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, all seven registers, `ext_out` and `status` are cleared to 0.
- R2: A source code of 000 in the A or B field selects `ext_in` as that operand. Codes 001 to 111 select registers 1 to 7.
- R3: A destination code of 000 leaves every register unchanged, and the result still appears on `ext_out`.
- R4: A destination code k of 1 to 7 loads the ALU result into register k on the rising edge, and loads only that register.
- R5: `ext_out` and `status` are registered. They change only at a rising edge and reflect the control word and `ext_in` sampled at that edge.
- R6: Arithmetic operations: 00010 gives A+B, 00101 gives A+(~B)+1, 00001 gives A+1, and 00110 gives A+0xFF (decrement). All results are taken modulo 256.
- R7: Logic and transfer operations: 00000 gives A, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, and 01110 gives NOT A. Each of these forces carry and overflow to 0.
- R8: Operation 10000 shifts A right and operation 11000 shifts A left. Both fill the vacated bit with 0, and carry takes the bit shifted out. Overflow is 0.
- R9: `status[2]` (sign) equals bit 7 of the result. `status[1]` (zero) is 1 exactly when the result is 0x00.
- R10: For arithmetic operations, `status[3]` (carry) is the carry out of bit 7 and `status[0]` (overflow) is the XOR of the carry into and the carry out of bit 7. For example, 0xF0 minus 0x14 gives 0xDC with status 1100.
- R11: Any operation code not listed above passes A through unchanged, with carry and overflow equal to 0.
- R12: A register used both as a source and as the destination in one control word supplies its old value, and it holds the new value from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | 14 | Control word: A select, B select, destination, operation |
| ext_in | input | 8 | External data, used as an operand by source code 000 |
| ext_out | output | 8 | Registered ALU result |
| status | output | 4 | Registered flags {carry, sign, zero, overflow} |

## Verification
Two functions can coincide in one cycle. A register can be read as an operand on the same edge that writes it, and the result can be captured on the output while the register write is suppressed. To provoke the first case, the bench increments register 4 into itself and adds register 5 to itself with register 5 as the destination. It then reads each register back through a transfer and expects exactly one step of change. To provoke the second case, it runs an operation with destination 000, checks the result on `ext_out` in that cycle, and then reads all seven registers back to confirm none of them moved.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int OPR_W = 5;

  typedef enum logic [OPR_W-1:0] {
    OP_TSFA = 5'b00000,
    OP_INCA = 5'b00001,
    OP_ADD  = 5'b00010,
    OP_SUB  = 5'b00101,
    OP_DECA = 5'b00110,
    OP_AND  = 5'b01000,
    OP_OR   = 5'b01010,
    OP_XOR  = 5'b01100,
    OP_COMA = 5'b01110,
    OP_SHRA = 5'b10000,
    OP_SHLA = 5'b11000
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [SEL_W-1:0]                 dst_sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  // one-hot load enables; code 0 enables nothing
  logic [NUM_REGS-1:0] load_en;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] cell_q;

    assign load_en[g] = (dst_sel == SEL_W'(g + 1));

    always_ff @(posedge clk) begin
      if (rst)
        cell_q <= '0;
      else if (load_en[g])
        cell_q <= wr_data;
    end

    assign regs_q[g] = cell_q;
  end
endmodule

// File: rtl/dp_srcsel.sv
module dp_srcsel #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]                 src_sel,
  input  logic [DATA_W-1:0]                ext_data,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic [DATA_W-1:0]                operand
);
  always_comb begin
    operand = ext_data;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (src_sel == SEL_W'(i + 1))
        operand = regs[i];
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [OPR_W-1:0]  opr,
  output logic [DATA_W-1:0] result,
  output flags_t            flags
);
  logic [DATA_W-1:0] addend;
  logic              cin;
  logic              is_arith;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] low_sum;
  logic              carry_into_msb;

  // operand conditioning for the single shared adder
  always_comb begin
    addend   = op_b;
    cin      = 1'b0;
    is_arith = 1'b1;
    case (opr)
      OP_ADD:  begin addend = op_b;  cin = 1'b0; end
      OP_SUB:  begin addend = ~op_b; cin = 1'b1; end
      OP_INCA: begin addend = '0;    cin = 1'b1; end
      OP_DECA: begin addend = '1;    cin = 1'b0; end
      default: is_arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, op_a} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
  assign low_sum = {1'b0, op_a[DATA_W-2:0]} + {1'b0, addend[DATA_W-2:0]}
                 + {{(DATA_W-1){1'b0}}, cin};
  assign carry_into_msb = low_sum[DATA_W-1];

  always_comb begin
    result  = op_a;
    flags.c = 1'b0;
    flags.v = 1'b0;
    if (is_arith) begin
      result  = sum[DATA_W-1:0];
      flags.c = sum[DATA_W];
      flags.v = sum[DATA_W] ^ carry_into_msb;
    end else begin
      case (opr)
        OP_AND:  result = op_a & op_b;
        OP_OR:   result = op_a | op_b;
        OP_XOR:  result = op_a ^ op_b;
        OP_COMA: result = ~op_a;
        OP_SHRA: begin
          result  = {1'b0, op_a[DATA_W-1:1]};
          flags.c = op_a[0];
        end
        OP_SHLA: begin
          result  = {op_a[DATA_W-2:0], 1'b0};
          flags.c = op_a[DATA_W-1];
        end
        default: result = op_a;
      endcase
    end
    flags.s = result[DATA_W-1];
    flags.z = (result == '0);
  end
endmodule

// File: rtl/ctrl_datapath.sv
module ctrl_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1,
  localparam int CW_W     = 3 * SEL_W + OPR_W,
  localparam int OPR_LSB  = 0,
  localparam int SELD_LSB = OPR_W,
  localparam int SELB_LSB = OPR_W + SEL_W,
  localparam int SELA_LSB = OPR_W + 2 * SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_in,
  output logic [DATA_W-1:0] ext_out,
  output logic [3:0]        status
);
  logic [SEL_W-1:0]                sel_a, sel_b, sel_d;
  logic [OPR_W-1:0]                opr;
  logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;
  logic [DATA_W-1:0]               bus_a, bus_b, alu_res;
  flags_t                          alu_flags;

  assign sel_a = ctrl_word[SELA_LSB +: SEL_W];
  assign sel_b = ctrl_word[SELB_LSB +: SEL_W];
  assign sel_d = ctrl_word[SELD_LSB +: SEL_W];
  assign opr   = ctrl_word[OPR_LSB  +: OPR_W];

  dp_srcsel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel_a (
    .src_sel (sel_a),
    .ext_data(ext_in),
    .regs    (rf_q),
    .operand (bus_a)
  );

  dp_srcsel #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_sel_b (
    .src_sel (sel_b),
    .ext_data(ext_in),
    .regs    (rf_q),
    .operand (bus_b)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op_a  (bus_a),
    .op_b  (bus_b),
    .opr   (opr),
    .result(alu_res),
    .flags (alu_flags)
  );

  dp_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .dst_sel(sel_d),
    .wr_data(alu_res),
    .regs_q (rf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_out <= '0;
      status  <= '0;
    end else begin
      ext_out <= alu_res;
      status  <= alu_flags;
    end
  end
endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1,
  localparam int OPR_W    = 5,
  localparam int CW_W     = 3 * SEL_W + OPR_W
) (
  input logic                            clk,
  input logic                            rst,
  input logic [CW_W-1:0]                 ctrl_word,
  input logic [DATA_W-1:0]               ext_out,
  input logic [3:0]                      status,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  logic [SEL_W-1:0] dst_now;
  logic [SEL_W-1:0] dst_d;
  logic [OPR_W-1:0] op_now;
  logic             logic_class;

  assign dst_now = ctrl_word[OPR_W +: SEL_W];
  assign op_now  = ctrl_word[OPR_W-1:0];
  assign logic_class = (op_now == 5'b00000) || (op_now == 5'b01000) ||
                       (op_now == 5'b01010) || (op_now == 5'b01100) ||
                       (op_now == 5'b01110);

  always_ff @(posedge clk) dst_d <= dst_now;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (ext_out == '0 && status == '0)); // R1

  AST_NO_DEST_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dst_now == '0) |=> $stable(regs)); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (dst_now != '0) |=> (regs[dst_d - 1'b1] == ext_out)); // R4

  AST_LOGIC_NO_CV: assert property (@(posedge clk) disable iff (rst)
    logic_class |=> (status[3] == 1'b0 && status[0] == 1'b0)); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status[1] == (ext_out == '0))); // R9

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status[2] == ext_out[DATA_W-1])); // R9
endmodule

bind ctrl_datapath dp_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_word(ctrl_word),
  .ext_out  (ext_out),
  .status   (status),
  .regs     (rf_q)
);

// File: tb/test_ctrl_datapath.sv
module test_ctrl_datapath;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_in = '0;
  logic [7:0]  ext_out;
  logic [3:0]  status;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  ctrl_datapath i_ctrl_datapath (
    .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
    .ext_in(ext_in), .ext_out(ext_out), .status(status)
  );

  function automatic logic [13:0] cw(input logic [2:0] a, input logic [2:0] b,
                                     input logic [2:0] d, input logic [4:0] op);
    return {a, b, d, op};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one control word, sample just after the capturing edge
  task automatic step(input logic [13:0] c, input logic [7:0] din);
    @(negedge clk);
    ctrl_word = c;
    ext_in    = din;
    @(posedge clk);
    #1;
  endtask

  task automatic check_op(input string req, input logic [13:0] c, input logic [7:0] din,
                          input logic [7:0] exp_out, input logic [3:0] exp_st);
    step(c, din);
    chk(req, {status, ext_out}, {exp_st, exp_out});
  endtask

  task automatic read_reg(input string req, input int k, input logic [7:0] exp);
    step(cw(3'(k), 3'd0, 3'd0, 5'b00000), 8'h00);
    chk(req, {4'h0, ext_out}, {4'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 out", {status, ext_out}, 12'h000);
    for (int k = 1; k <= 7; k++) read_reg("R1 reg", k, 8'h00);
  endtask

  task automatic t_load;
    for (int k = 1; k <= 7; k++)
      check_op("R2 ext load", cw(3'd0, 3'd0, 3'(k), 5'b00000), 8'(k * 17),
               8'(k * 17), 4'b0000);
    for (int k = 1; k <= 7; k++) read_reg("R4 readback", k, 8'(k * 17));
  endtask

  task automatic t_no_dest;
    // R3: XOR ext with R1 (0x11), no destination
    check_op("R3 result shown", cw(3'd0, 3'd1, 3'd0, 5'b01100), 8'hFF, 8'hEE, 4'b0100);
    for (int k = 1; k <= 7; k++) read_reg("R3 unchanged", k, 8'(k * 17));
  endtask

  task automatic t_timing;
    check_op("R5 first", cw(3'd0, 3'd0, 3'd0, 5'b00000), 8'h3C, 8'h3C, 4'b0000);
    @(negedge clk);
    ctrl_word = cw(3'd0, 3'd0, 3'd0, 5'b00000);
    ext_in    = 8'hC3;
    #1;
    chk("R5 held before edge", {status, ext_out}, {4'b0000, 8'h3C});
    @(posedge clk);
    #1;
    chk("R5 after edge", {status, ext_out}, {4'b0100, 8'hC3});
  endtask

  task automatic t_arith;
    step(cw(3'd0, 3'd0, 3'd2, 5'b00000), 8'h14);
    step(cw(3'd0, 3'd0, 3'd3, 5'b00000), 8'h01);
    check_op("R10 sub example", cw(3'd0, 3'd2, 3'd0, 5'b00101), 8'hF0, 8'hDC, 4'b1100);
    check_op("R10 add overflow", cw(3'd0, 3'd3, 3'd0, 5'b00010), 8'h7F, 8'h80, 4'b0101);
    check_op("R6 add wrap", cw(3'd0, 3'd3, 3'd0, 5'b00010), 8'hFF, 8'h00, 4'b1010);
    check_op("R6 inc wrap", cw(3'd0, 3'd0, 3'd0, 5'b00001), 8'hFF, 8'h00, 4'b1010);
    check_op("R6 dec zero", cw(3'd0, 3'd0, 3'd0, 5'b00110), 8'h00, 8'hFF, 4'b0100);
    check_op("R10 dec overflow", cw(3'd0, 3'd0, 3'd0, 5'b00110), 8'h80, 8'h7F, 4'b1001);
    check_op("R10 sub overflow", cw(3'd0, 3'd3, 3'd0, 5'b00101), 8'h80, 8'h7F, 4'b1001);
  endtask

  task automatic t_logic;
    check_op("R7 and", cw(3'd0, 3'd2, 3'd0, 5'b01000), 8'hF0, 8'h10, 4'b0000);
    check_op("R7 or",  cw(3'd0, 3'd2, 3'd0, 5'b01010), 8'hF0, 8'hF4, 4'b0100);
    check_op("R7 xor", cw(3'd0, 3'd2, 3'd0, 5'b01100), 8'hF0, 8'hE4, 4'b0100);
    check_op("R7 com", cw(3'd0, 3'd0, 3'd0, 5'b01110), 8'hF0, 8'h0F, 4'b0000);
    check_op("R9 zero xor self", cw(3'd2, 3'd2, 3'd0, 5'b01100), 8'h00, 8'h00, 4'b0010);
    check_op("R7 tsf", cw(3'd0, 3'd0, 3'd0, 5'b00000), 8'h80, 8'h80, 4'b0100);
  endtask

  task automatic t_shift;
    check_op("R8 shr carry", cw(3'd0, 3'd0, 3'd0, 5'b10000), 8'h81, 8'h40, 4'b1000);
    check_op("R8 shl carry", cw(3'd0, 3'd0, 3'd0, 5'b11000), 8'h81, 8'h02, 4'b1000);
    check_op("R8 shl sign",  cw(3'd0, 3'd0, 3'd0, 5'b11000), 8'h40, 8'h80, 4'b0100);
    check_op("R8 shr zero",  cw(3'd0, 3'd0, 3'd0, 5'b10000), 8'h01, 8'h00, 4'b1010);
  endtask

  task automatic t_unused;
    check_op("R11 code 00011", cw(3'd0, 3'd0, 3'd0, 5'b00011), 8'hA5, 8'hA5, 4'b0100);
    check_op("R11 code 11111", cw(3'd0, 3'd0, 3'd0, 5'b11111), 8'h00, 8'h00, 4'b0010);
  endtask

  task automatic t_same_reg;
    check_op("R12 inc R4 into R4", cw(3'd4, 3'd0, 3'd4, 5'b00001), 8'h00, 8'h45, 4'b0000);
    read_reg("R12 R4 after", 4, 8'h45);
    check_op("R12 R5+R5 into R5", cw(3'd5, 3'd5, 3'd5, 5'b00010), 8'h00, 8'hAA, 4'b0101);
    read_reg("R12 R5 after", 5, 8'hAA);
    read_reg("R4 neighbour R6", 6, 8'h66);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", {status, ext_out}, 12'h000);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load();
    t_no_dest();
    t_timing();
    t_arith();
    t_logic();
    t_shift();
    t_unused();
    t_same_reg();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule